// File: doc/BRIEF.md
# Four-Phase to Transition-Signalled Quad-Rail Link Bridge

This block joins a local four-phase, return-to-zero one-hot handshake to a die-to-die link that signals each 2-bit symbol by flipping exactly one of four wires. It holds both directions. On the send side, a one-hot code offered on `txSym` flips the matching link wire. The local acknowledge `txAck` is raised once the far end has flipped the returning acknowledge wire. On the receive side, a single wire flip on the incoming link is turned back into a held one-hot code on `rxSym`. The returning acknowledge wire is flipped only after the local consumer has finished its full return-to-zero cycle.

Both halves are modelled as synchronous logic. Each link wire is compared against a registered reference level to detect transitions. A send-side input with more than one rail high is refused and flagged. On the receive side, flips seen on two or more wires in the same cycle are refused and flagged. The two link directions can be looped back onto each other to form a complete channel.

Top module: `qrail_bridge`

## Requirements
- R1: While reset is asserted and right after it, `linkTxRails`, `linkRxAck`, `rxSym`, `txAck`, `txErr` and `rxErr` are all zero.
- R2: When the send side is idle and `txSym` has exactly one bit set, bit i (value i), link wire `linkTxRails[i]` changes level at the next clock edge and no other link wire changes.
- R3: After a launch, `txAck` stays low and no further link wire changes until `linkTxAck` differs from its level at launch; `txAck` rises at the first clock edge that sees that difference.
- R4: While `txAck` is high, a held `txSym` is not sent again; `txAck` falls at the first clock edge that sees `txSym` all zero, and only then is a new symbol accepted.
- R5: A `txSym` with two or more bits set, sampled while idle, drives `txErr` high after that edge and changes no link wire; an all-zero `txSym` sends nothing and leaves `txErr` low.
- R6: When exactly one bit of `linkRxRails` differs from the receiver's reference level, `rxSym` shows that bit alone (one-hot) after the next clock edge and holds it until `rxAck` is seen high.
- R7: On seeing `rxAck` high while holding a symbol, `rxSym` returns to zero at that edge; `linkRxAck` changes level only at the first later edge that sees `rxAck` low, and at no other time.
- R8: When two or more link wires differ from the reference in the same cycle, `rxErr` is high for one cycle, `rxSym` stays zero, `linkRxAck` does not change, and the new wire levels become the reference, so a later single flip decodes correctly.
- R9: With `linkTxRails` looped to `linkRxRails` and `linkRxAck` looped to `linkTxAck`, a sequence of symbols, including repeated values, arrives on `rxSym` in order and each send completes with `txAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txSym | input | RAILS | Four-phase one-hot symbol to send |
| txAck | output | 1 | Four-phase acknowledge for the send side |
| txErr | output | 1 | Send-side input had more than one rail high |
| linkTxRails | output | RAILS | Transition-signalled outgoing link wires |
| linkTxAck | input | 1 | Toggle acknowledge returned by the far end |
| linkRxRails | input | RAILS | Transition-signalled incoming link wires |
| linkRxAck | output | 1 | Toggle acknowledge returned to the far end |
| rxSym | output | RAILS | Four-phase one-hot received symbol |
| rxAck | input | 1 | Four-phase acknowledge from the local consumer |
| rxErr | output | 1 | Incoming link showed flips on several wires at once |

## Verification
The send side is tried with every one-hot value, which tells a correct wire mapping from a swapped or shifted one. It is also tried with several multi-hot patterns and with an all-zero input, which separate refusal from idling. The receive side sees a single flip, a double flip and a flip after that, so a decoder that forgets to take the new reference shows up as a wrong symbol. A looped-back sequence with a repeated value checks that detection works on transitions, not levels, in both directions.

// File: rtl/qrail_pkg.sv
package qrail_pkg;

  typedef struct packed {
    logic txLaunch;
    logic txAckSet;
    logic txAckClr;
    logic txFlag;
    logic rxCapture;
    logic rxClear;
    logic rxAckFlip;
    logic rxDrop;
  } strobe_t;

  typedef struct packed {
    logic txOneHot;
    logic txMulti;
    logic txEmpty;
    logic linkAckMoved;
    logic rxOneTog;
    logic rxMultiTog;
    logic rxAckIn;
  } status_t;

  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_WAIT = 2'd1, TX_DONE = 2'd2} txState_t;
  typedef enum logic [1:0] {RX_IDLE = 2'd0, RX_HOLD = 2'd1, RX_RTZ = 2'd2} rxState_t;

endpackage

// File: rtl/qrail_ctrl.sv
module qrail_ctrl
  import qrail_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  status_t sts,
  output strobe_t stb
);

  txState_t txState, txNext;
  rxState_t rxState, rxNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      rxState <= RX_IDLE;
    end else begin
      txState <= txNext;
      rxState <= rxNext;
    end
  end

  // send side sequencing
  always_comb begin
    txNext       = txState;
    stb.txLaunch = 1'b0;
    stb.txAckSet = 1'b0;
    stb.txAckClr = 1'b0;
    stb.txFlag   = 1'b0;
    unique case (txState)
      TX_IDLE: begin
        if (sts.txOneHot) begin
          stb.txLaunch = 1'b1;
          txNext       = TX_WAIT;
        end else if (sts.txMulti) begin
          stb.txFlag = 1'b1;
        end
      end
      TX_WAIT: begin
        if (sts.linkAckMoved) begin
          stb.txAckSet = 1'b1;
          txNext       = TX_DONE;
        end
      end
      TX_DONE: begin
        if (sts.txEmpty) begin
          stb.txAckClr = 1'b1;
          txNext       = TX_IDLE;
        end
      end
      default: txNext = TX_IDLE;
    endcase
  end

  // receive side sequencing
  always_comb begin
    rxNext        = rxState;
    stb.rxCapture = 1'b0;
    stb.rxClear   = 1'b0;
    stb.rxAckFlip = 1'b0;
    stb.rxDrop    = 1'b0;
    unique case (rxState)
      RX_IDLE: begin
        if (sts.rxOneTog) begin
          stb.rxCapture = 1'b1;
          rxNext        = RX_HOLD;
        end else if (sts.rxMultiTog) begin
          stb.rxDrop = 1'b1;
        end
      end
      RX_HOLD: begin
        if (sts.rxAckIn) begin
          stb.rxClear = 1'b1;
          rxNext      = RX_RTZ;
        end
      end
      RX_RTZ: begin
        if (!sts.rxAckIn) begin
          stb.rxAckFlip = 1'b1;
          rxNext        = RX_IDLE;
        end
      end
      default: rxNext = RX_IDLE;
    endcase
  end

endmodule

// File: rtl/qrail_path.sv
module qrail_path
  import qrail_pkg::*;
#(
  parameter int RAILS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output status_t          sts,
  input  logic [RAILS-1:0] txSym,
  input  logic             linkTxAck,
  input  logic [RAILS-1:0] linkRxRails,
  input  logic             rxAck,
  output logic [RAILS-1:0] linkTxRails,
  output logic             txAck,
  output logic             txErr,
  output logic             linkRxAck,
  output logic [RAILS-1:0] rxSym,
  output logic             rxErr
);

  localparam int CW = $clog2(RAILS + 1);

  function automatic logic [CW-1:0] ones(input logic [RAILS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < RAILS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [RAILS-1:0] railRef;
  logic [RAILS-1:0] rxTog;
  logic             ackRef;
  logic [CW-1:0]    txCount;
  logic [CW-1:0]    rxCount;

  assign rxTog   = linkRxRails ^ railRef;
  assign txCount = ones(txSym);
  assign rxCount = ones(rxTog);

  assign sts.txOneHot     = (txCount == CW'(1));
  assign sts.txMulti      = (txCount > CW'(1));
  assign sts.txEmpty      = (txCount == '0);
  assign sts.linkAckMoved = (linkTxAck != ackRef);
  assign sts.rxOneTog     = (rxCount == CW'(1));
  assign sts.rxMultiTog   = (rxCount > CW'(1));
  assign sts.rxAckIn      = rxAck;

  for (genvar g = 0; g < RAILS; g++) begin : gRail
    logic txBit;
    logic refBit;
    logic symBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txBit  <= 1'b0;
        refBit <= 1'b0;
        symBit <= 1'b0;
      end else begin
        if (stb.txLaunch && txSym[g]) txBit <= ~txBit;
        if (stb.rxCapture || stb.rxDrop) refBit <= linkRxRails[g];
        if (stb.rxCapture)    symBit <= rxTog[g];
        else if (stb.rxClear) symBit <= 1'b0;
      end
    end

    assign linkTxRails[g] = txBit;
    assign railRef[g]     = refBit;
    assign rxSym[g]       = symBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackRef    <= 1'b0;
      txAck     <= 1'b0;
      txErr     <= 1'b0;
      linkRxAck <= 1'b0;
      rxErr     <= 1'b0;
    end else begin
      if (stb.txLaunch) ackRef <= linkTxAck;
      if (stb.txAckSet)      txAck <= 1'b1;
      else if (stb.txAckClr) txAck <= 1'b0;
      txErr <= stb.txFlag;
      if (stb.rxAckFlip) linkRxAck <= ~linkRxAck;
      rxErr <= stb.rxDrop;
    end
  end

endmodule

// File: rtl/qrail_bridge.sv
module qrail_bridge
  import qrail_pkg::*;
#(
  parameter int RAILS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RAILS-1:0] txSym,
  output logic             txAck,
  output logic             txErr,
  output logic [RAILS-1:0] linkTxRails,
  input  logic             linkTxAck,
  input  logic [RAILS-1:0] linkRxRails,
  output logic             linkRxAck,
  output logic [RAILS-1:0] rxSym,
  input  logic             rxAck,
  output logic             rxErr
);

  strobe_t stb;
  status_t sts;

  qrail_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .sts  (sts),
    .stb  (stb)
  );

  qrail_path #(.RAILS(RAILS)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sts         (sts),
    .txSym       (txSym),
    .linkTxAck   (linkTxAck),
    .linkRxRails (linkRxRails),
    .rxAck       (rxAck),
    .linkTxRails (linkTxRails),
    .txAck       (txAck),
    .txErr       (txErr),
    .linkRxAck   (linkRxAck),
    .rxSym       (rxSym),
    .rxErr       (rxErr)
  );

endmodule

// File: rtl/qrail_bridge_chk.sv
module qrail_bridge_chk #(
  parameter int RAILS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [RAILS-1:0] txSym,
  input logic             txAck,
  input logic             txErr,
  input logic [RAILS-1:0] linkTxRails,
  input logic             linkTxAck,
  input logic [RAILS-1:0] linkRxRails,
  input logic             linkRxAck,
  input logic [RAILS-1:0] rxSym,
  input logic             rxAck,
  input logic             rxErr
);

  // R2: at most one link wire flips per edge
  p_single_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(linkTxRails ^ $past(linkTxRails)) <= 1);

  // R4: nothing is launched while the local acknowledge is high
  p_no_launch_in_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (linkTxRails != $past(linkTxRails)) |-> !$past(txAck));

  // R5: an error flag never comes with a launch
  p_err_no_send_r5: assert property (@(posedge clk) disable iff (!rstN)
    txErr |-> (linkTxRails == $past(linkTxRails)));

  // R6: received code is never multi-hot
  p_rx_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxSym));

  // R6: held code stays until the consumer acknowledges
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxSym) != '0 && !$past(rxAck)) |-> (rxSym == $past(rxSym)));

  // R7: link acknowledge flips only after return-to-zero on both wires
  p_ack_after_rtz_r7: assert property (@(posedge clk) disable iff (!rstN)
    (linkRxAck != $past(linkRxAck)) |-> (!$past(rxAck) && $past(rxSym) == '0));

  // R8: a refused double flip shows no symbol
  p_err_no_sym_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> (rxSym == '0));

endmodule

bind qrail_bridge qrail_bridge_chk #(.RAILS(RAILS)) uChk (.*);

// File: tb/qrail_bridge_test.sv
module qrail_bridge_test;

  localparam int RAILS = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [RAILS-1:0] txSym = '0;
  logic             txAck, txErr, linkRxAck, rxErr;
  logic [RAILS-1:0] linkTxRails, rxSym;
  logic             rxAck = 1'b0;
  logic             loopMode = 1'b0;
  logic [RAILS-1:0] manualRails = '0;
  logic             manualAck = 1'b0;
  logic [RAILS-1:0] linkRxRailsIn;
  logic             linkTxAckIn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  assign linkRxRailsIn = loopMode ? linkTxRails : manualRails;
  assign linkTxAckIn   = loopMode ? linkRxAck : manualAck;

  always #2 clk = ~clk;

  qrail_bridge #(.RAILS(RAILS)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .txSym       (txSym),
    .txAck       (txAck),
    .txErr       (txErr),
    .linkTxRails (linkTxRails),
    .linkTxAck   (linkTxAckIn),
    .linkRxRails (linkRxRailsIn),
    .linkRxAck   (linkRxAck),
    .rxSym       (rxSym),
    .rxAck       (rxAck),
    .rxErr       (rxErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {txSym, expected flipped wires, expected error}
  localparam logic [8:0] VEC [0:7] = '{
    9'b0001_0001_0, 9'b0010_0010_0, 9'b0100_0100_0, 9'b1000_1000_0,
    9'b0011_0000_1, 9'b1111_0000_1, 9'b0110_0000_1, 9'b0000_0000_0
  };

  task automatic waitFor(input int what, input string req);
    int n;
    n = 0;
    while (n < 50) begin
      if ((what == 0 && rxSym != '0) || (what == 1 && rxSym == '0) ||
          (what == 2 && txAck) || (what == 3 && !txAck)) break;
      @(negedge clk);
      n++;
    end
    if (n >= 50) chk(1'b0, req, n, 0);
  endtask

  task automatic sendLoop(input int v);
    @(negedge clk);
    txSym = RAILS'(1) << v;
    waitFor(0, "R9 wait symbol");
    chk(rxSym == (RAILS'(1) << v), "R9 looped symbol", rxSym, 1 << v);
    rxAck = 1'b1;
    waitFor(1, "R9 wait rtz");
    rxAck = 1'b0;
    waitFor(2, "R9 wait txAck");
    chk(txAck == 1'b1, "R9 send completes", txAck, 1);
    txSym = '0;
    waitFor(3, "R9 wait txAck low");
  endtask

  initial begin
    logic [RAILS-1:0] prev;
    logic             ackPrev;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({linkTxRails, rxSym, linkRxAck, txAck, txErr, rxErr} == '0, "R1 reset state",
        {linkTxRails, rxSym, linkRxAck, txAck, txErr, rxErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({linkTxRails, rxSym, linkRxAck, txAck} == '0, "R1 after release",
        {linkTxRails, rxSym, linkRxAck, txAck}, 0);

    // send-side vectors with the acknowledge driven by hand
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      prev  = linkTxRails;
      txSym = VEC[i][8:5];
      @(negedge clk);
      chk((linkTxRails ^ prev) == VEC[i][4:1], "R2/R5 wire flip",
          linkTxRails ^ prev, VEC[i][4:1]);
      chk(txErr == VEC[i][0], "R5 error flag", txErr, VEC[i][0]);
      if (VEC[i][4:1] != '0) begin
        prev = linkTxRails;
        @(negedge clk);
        chk(txAck == 1'b0, "R3 no ack before link ack", txAck, 0);
        chk(linkTxRails == prev, "R3 no relaunch while waiting", linkTxRails, prev);
        manualAck = ~manualAck;
        @(negedge clk);
        chk(txAck == 1'b1, "R3 ack after link ack", txAck, 1);
        @(negedge clk);
        chk(linkTxRails == prev, "R4 held symbol not resent", linkTxRails, prev);
        txSym = '0;
        @(negedge clk);
        chk(txAck == 1'b0, "R4 ack falls after rtz", txAck, 0);
      end else begin
        txSym = '0;
        @(negedge clk);
        chk(txErr == 1'b0, "R5 error clears on zero", txErr, 0);
      end
    end

    // receive side, hand-driven link wires
    ackPrev = linkRxAck;
    @(negedge clk);
    manualRails = manualRails ^ 4'b0100;
    @(negedge clk);
    chk(rxSym == 4'b0100, "R6 single flip decoded", rxSym, 4'b0100);
    @(negedge clk);
    chk(rxSym == 4'b0100, "R6 symbol held", rxSym, 4'b0100);
    chk(linkRxAck == ackPrev, "R7 no ack while held", linkRxAck, ackPrev);
    rxAck = 1'b1;
    @(negedge clk);
    chk(rxSym == '0, "R7 rtz on ack", rxSym, 0);
    @(negedge clk);
    chk(linkRxAck == ackPrev, "R7 no link ack while rxAck high", linkRxAck, ackPrev);
    rxAck = 1'b0;
    @(negedge clk);
    chk(linkRxAck == ~ackPrev, "R7 link ack flips after rtz", linkRxAck, ~ackPrev);
    ackPrev = linkRxAck;
    manualRails = manualRails ^ 4'b0011;
    @(negedge clk);
    chk(rxErr == 1'b1, "R8 double flip flagged", rxErr, 1);
    chk(rxSym == '0, "R8 no symbol on error", rxSym, 0);
    @(negedge clk);
    chk(rxErr == 1'b0, "R8 error lasts one cycle", rxErr, 0);
    chk(linkRxAck == ackPrev, "R8 no link ack on error", linkRxAck, ackPrev);
    manualRails = manualRails ^ 4'b0001;
    @(negedge clk);
    chk(rxSym == 4'b0001, "R8 resync then decode", rxSym, 4'b0001);
    rxAck = 1'b1;
    @(negedge clk);
    rxAck = 1'b0;
    @(negedge clk);

    // reset again, then loop the two directions together
    rstN = 1'b0;
    loopMode = 1'b1;
    repeat (2) @(negedge clk);
    chk({linkTxRails, rxSym, linkRxAck, txAck} == '0, "R1 reset mid-run",
        {linkTxRails, rxSym, linkRxAck, txAck}, 0);
    rstN = 1'b1;
    sendLoop(3);
    sendLoop(0);
    sendLoop(2);
    sendLoop(2);
    sendLoop(1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule